// File: doc/BRIEF.md
# Event Combiner and Interrupt Selector

This block gathers single-cycle system event pulses and turns them into a small set of CPU interrupt lines. Every event pulse sets a sticky flag that software clears by writing ones. The flags are grouped into fixed-width banks. Each bank has a combiner: it ORs together the flags that its own mask leaves open. The combiner outputs re-enter the event space as the lowest event numbers. This lets a whole group of events reach the CPU through a single interrupt line.

Each CPU interrupt output has its own selector register, which names the event that drives it. An output gives a one-cycle pulse on each rising edge of its selected event. A combiner level that stays high therefore raises one interrupt, not a stream of them. A single write port with a two-bit kind code covers four things: setting flags, clearing flags, writing combiner masks and writing selectors.

Top module: `evt_router`

## Requirements
- R1: A one-cycle pulse on `evt_i[n]` (n ≥ NUM_BANKS) sets `flags_o[n]` at the next clock edge. The flag holds until it is cleared. All flags are 0 after reset.
- R2: A write with kind 1 (clear) to bank b clears every flag `b*BANK_W+i` for which `wr_data[i]` is 1. If an event pulse and a clear hit the same flag in the same cycle, the flag ends up set.
- R3: A write with kind 0 (set) to bank b sets every flag `b*BANK_W+i` for which `wr_data[i]` is 1.
- R4: Flags 0 to NUM_BANKS-1 always read 0. Pulses and set writes aimed at them are ignored, because those event numbers belong to the combiners.
- R5: `comb_o[b]` is the OR of the flags in bank b whose mask bit is 0. A write with kind 2 loads the bank-b mask from `wr_data`. All masks reset to all ones, meaning fully masked.
- R6: Combiner output b acts as event number b when a selector picks an event.
- R7: Selector k resets to event NUM_BANKS+k. A write with kind 3 and `wr_addr` = k loads selector k from `wr_data[SEL_W-1:0]` at the next edge.
- R8: `irq_o[k]` is high for exactly one cycle. That cycle is the one after the selected event goes from low to high.
- R9: A selected event that stays high raises only one pulse. A new pulse needs the event to fall and rise again.
- R10: A selector write that switches to an event which is already high produces no pulse.
- R11: A selector value of NUM_EVT or more keeps its output low. Set, clear and mask writes to `wr_addr` ≥ NUM_BANKS are ignored. Selector writes to `wr_addr` ≥ NUM_OUT are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVT | Event pulses, one cycle each |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 set, 1 clear, 2 mask, 3 selector |
| wr_addr | input | ADDR_W | Bank index, or output index for selector writes |
| wr_data | input | BANK_W | Write data |
| flags_o | output | NUM_EVT | Sticky event flags |
| comb_o | output | NUM_BANKS | Combiner outputs, which are events 0..NUM_BANKS-1 |
| irq_o | output | NUM_OUT | Interrupt pulses |

## Verification
The bench builds the block with 64 events in two 32-bit banks, keeping the 7-bit selector and twelve outputs. This makes selector values 64 to 127 point at events that do not exist, and bank addresses 2 and 3 fall out of range. Both ignore cases (R11) can therefore be exercised. With two banks, the default selectors map outputs to events 2 to 13. The combiners are events 0 and 1. One combiner can be routed through an ordinary selector and held high to check the single-pulse rule.

// File: rtl/evt_router_pkg.sv
// Package: shared write-kind encoding for the event router.
package evt_router_pkg;
    typedef enum logic [1:0] {
        WK_SET  = 2'd0,
        WK_CLR  = 2'd1,
        WK_MASK = 2'd2,
        WK_SEL  = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/evt_router_flags.sv
// Module: sticky event flag bank.
// Purpose: latches event pulses and software set writes; clears on write-one.
// Assumes: NUM_EVT = NUM_BANKS*BANK_W; set beats clear; low NUM_BANKS flags are reserved.
module evt_router_flags
    import evt_router_pkg::*;
#(
    parameter int NUM_EVT   = 128,
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               wr_en,
    input  wr_kind_e           wr_kind,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BANK_W-1:0]  wr_data,
    output logic [NUM_EVT-1:0] flags_o
);
    localparam logic [NUM_EVT-1:0] RSVD =
        {{(NUM_EVT-NUM_BANKS){1'b0}}, {NUM_BANKS{1'b1}}};

    logic [NUM_EVT-1:0] flags_q;
    logic [NUM_EVT-1:0] flags_d;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        logic [BANK_W-1:0] sw_set, sw_clr;
        assign hit    = wr_en && (wr_addr == ADDR_W'(b));
        assign sw_set = (hit && wr_kind == WK_SET) ? wr_data : '0;
        assign sw_clr = (hit && wr_kind == WK_CLR) ? wr_data : '0;
        // Next flag value: clear first, then any set source wins.
        assign flags_d[b*BANK_W +: BANK_W] =
            (flags_q[b*BANK_W +: BANK_W] & ~sw_clr) | sw_set | evt_i[b*BANK_W +: BANK_W];
    end

    // Flag register with reserved low bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d & ~RSVD;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/evt_router_comb.sv
// Module: per-bank combiner with mask registers.
// Purpose: ORs the unmasked flags of each bank into one level.
// Assumes: mask bit 1 means masked; masks reset to all ones.
module evt_router_comb
    import evt_router_pkg::*;
#(
    parameter int NUM_EVT   = 128,
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  wr_kind_e             wr_kind,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BANK_W-1:0]    wr_data,
    input  logic [NUM_EVT-1:0]   flags_i,
    output logic [NUM_BANKS-1:0] comb_o
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] mask_q;

        // Mask register for this bank.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q <= '1;
            else if (wr_en && wr_kind == WK_MASK && wr_addr == ADDR_W'(b))
                mask_q <= wr_data;
        end

        // Combiner level for this bank.
        assign comb_o[b] = |(flags_i[b*BANK_W +: BANK_W] & ~mask_q);
    end
endmodule

// File: rtl/evt_router_sel.sv
// Module: interrupt selectors with rising-edge pulse generation.
// Purpose: each output picks one event and pulses on its rising edge.
// Assumes: NUM_EVT <= 2**SEL_W; values >= NUM_EVT select a constant zero.
module evt_router_sel
    import evt_router_pkg::*;
#(
    parameter int NUM_EVT   = 128,
    parameter int NUM_BANKS = 4,
    parameter int NUM_OUT   = 12,
    parameter int SEL_W     = 7,
    parameter int ADDR_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  wr_kind_e           wr_kind,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [NUM_EVT-1:0] ev_i,
    output logic [NUM_OUT-1:0] irq_o
);
    localparam int SPAN = 2 ** SEL_W;

    logic [SPAN-1:0] ev_pad;

    // Pad the event vector so every selector value is a legal index.
    always_comb begin
        ev_pad = '0;
        ev_pad[NUM_EVT-1:0] = ev_i;
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic [SEL_W-1:0] sel_q, sel_d;
        logic prev_q, irq_q;

        // Selector value in force from the next edge.
        assign sel_d = (wr_en && wr_kind == WK_SEL && wr_addr == ADDR_W'(k)) ? wr_sel : sel_q;

        // Selector, previous-level and pulse registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q  <= SEL_W'(NUM_BANKS + k);
                prev_q <= 1'b0;
                irq_q  <= 1'b0;
            end else begin
                sel_q  <= sel_d;
                prev_q <= ev_pad[sel_d];
                irq_q  <= ev_pad[sel_q] & ~prev_q;
            end
        end

        assign irq_o[k] = irq_q;
    end
endmodule

// File: rtl/evt_router.sv
// Module: event router top.
// Purpose: flags -> combiners -> event space -> selectable interrupt pulses.
// Assumes: NUM_EVT = NUM_BANKS*BANK_W, ADDR_W covers NUM_BANKS and NUM_OUT.
module evt_router
    import evt_router_pkg::*;
#(
    parameter int NUM_EVT = 128,
    parameter int BANK_W  = 32,
    parameter int NUM_OUT = 12,
    parameter int SEL_W   = 7,
    parameter int ADDR_W  = 4,
    localparam int NUM_BANKS = NUM_EVT / BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic                 wr_en,
    input  logic [1:0]           wr_kind,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BANK_W-1:0]    wr_data,
    output logic [NUM_EVT-1:0]   flags_o,
    output logic [NUM_BANKS-1:0] comb_o,
    output logic [NUM_OUT-1:0]   irq_o
);
    wr_kind_e           kind;
    logic [NUM_EVT-1:0] ev;

    assign kind = wr_kind_e'(wr_kind);

    evt_router_flags #(
        .NUM_EVT(NUM_EVT), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_kind(kind),
        .wr_addr(wr_addr), .wr_data(wr_data), .flags_o(flags_o)
    );

    evt_router_comb #(
        .NUM_EVT(NUM_EVT), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
    ) u_comb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(kind), .wr_addr(wr_addr),
        .wr_data(wr_data), .flags_i(flags_o), .comb_o(comb_o)
    );

    // Event space: combiners occupy the lowest numbers.
    assign ev = {flags_o[NUM_EVT-1:NUM_BANKS], comb_o};

    evt_router_sel #(
        .NUM_EVT(NUM_EVT), .NUM_BANKS(NUM_BANKS), .NUM_OUT(NUM_OUT),
        .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(kind), .wr_addr(wr_addr),
        .wr_sel(wr_data[SEL_W-1:0]), .ev_i(ev), .irq_o(irq_o)
    );
endmodule

// File: rtl/evt_router_chk.sv
// Module: assertion checker for evt_router, attached by bind.
// Assumes: sees only the top-level ports.
module evt_router_chk #(
    parameter int NUM_EVT   = 128,
    parameter int BANK_W    = 32,
    parameter int NUM_OUT   = 12,
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_EVT-1:0]   evt_i,
    input logic [NUM_EVT-1:0]   flags_o,
    input logic [NUM_BANKS-1:0] comb_o,
    input logic [NUM_OUT-1:0]   irq_o
);
    localparam logic [NUM_EVT-1:0] RSVD =
        {{(NUM_EVT-NUM_BANKS){1'b0}}, {NUM_BANKS{1'b1}}};

    logic up_q;

    // Marks that the previous cycle was out of reset.
    always_ff @(posedge clk) up_q <= rst_n;

    // R1: a pulse on a non-reserved event is reflected in the flags next cycle.
    a_r1_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> ((($past(evt_i) & ~RSVD) & ~flags_o) == '0));

    // R4: reserved flags never set.
    a_r4_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & RSVD) == '0);

    // R9: no output pulses on two consecutive cycles.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> ((irq_o & $past(irq_o)) == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // R5: a combiner is high only if some flag in its bank is set.
        a_r5_comb_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            comb_o[b] |-> (|flags_o[b*BANK_W +: BANK_W]));
    end
endmodule

bind evt_router evt_router_chk #(
    .NUM_EVT(NUM_EVT), .BANK_W(BANK_W), .NUM_OUT(NUM_OUT), .NUM_BANKS(NUM_BANKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .flags_o(flags_o),
    .comb_o(comb_o), .irq_o(irq_o)
);

// File: tb/evt_router_bench.sv
module evt_router_bench;
    localparam int NE = 64;
    localparam int BW = 32;
    localparam int NO = 12;
    localparam int SW = 7;
    localparam int AW = 4;
    localparam int NB = NE / BW;

    localparam logic [1:0] K_SET = 2'd0, K_CLR = 2'd1, K_MASK = 2'd2, K_SEL = 2'd3;

    // Vector: {event index, expected irq_o one cycle after the flag rises}
    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {7'd2,  12'h001},
        {7'd5,  12'h008},
        {7'd13, 12'h800},
        {7'd14, 12'h000},
        {7'd40, 12'h000},
        {7'd1,  12'h000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_i = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = 2'd0;
    logic [AW-1:0] wr_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic [NE-1:0] flags_o;
    logic [NB-1:0] comb_o;
    logic [NO-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evt_router #(.NUM_EVT(NE), .BANK_W(BW), .NUM_OUT(NO), .SEL_W(SW), .ADDR_W(AW)) u_evt_router (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data), .flags_o(flags_o), .comb_o(comb_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int a, input logic [BW-1:0] d);
        wr_en = 1'b1; wr_kind = k; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input int n);
        evt_i[n] = 1'b1;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NE-1:0] snap;
        @(negedge clk);
        do_reset();
        chk(flags_o == '0, "R1 reset flags", flags_o, '0);
        chk(comb_o == '0,  "R5 reset comb", 64'(comb_o), '0);
        chk(irq_o == '0,   "R8 reset irq", 64'(irq_o), '0);

        // Table walk: default selector mapping (R7), pulse timing (R8), reserved events (R4)
        for (int i = 0; i < NV; i++) begin
            int ev;
            logic [NO-1:0] exp;
            ev  = int'(VEC[i][18:12]);
            exp = VEC[i][11:0];
            pulse(ev);
            chk(flags_o[ev] == (ev >= NB), "R1/R4 flag after pulse", 64'(flags_o[ev]), 64'(ev >= NB));
            @(negedge clk);
            chk(irq_o == exp, "R7/R8 irq from default mapping", 64'(irq_o), 64'(exp));
            @(negedge clk);
            chk(irq_o == '0, "R8 pulse is one cycle", 64'(irq_o), '0);
            wr(K_CLR, ev / BW, BW'(1) << (ev % BW));
            chk(flags_o == '0, "R2 clear after vector", flags_o, '0);
        end

        // Combiner routed through selector (R5, R6, R9)
        wr(K_MASK, 1, ~(BW'(1) << 8));
        wr(K_SEL, 0, 32'd1);
        pulse(40);
        chk(comb_o == 2'b10, "R5 combiner unmasked", 64'(comb_o), 64'h2);
        @(negedge clk);
        chk(irq_o == 12'h001, "R6 combiner as event", 64'(irq_o), 64'h1);
        pulse(41);
        chk(irq_o == '0, "R9 held level no repeat", 64'(irq_o), '0);
        @(negedge clk);
        chk(irq_o == '0, "R9 held level no repeat 2", 64'(irq_o), '0);
        wr(K_CLR, 1, BW'(1) << 8);
        chk(comb_o == '0, "R5 masked flag ignored", 64'(comb_o), '0);
        pulse(40);
        @(negedge clk);
        chk(irq_o == 12'h001, "R9 new rise pulses again", 64'(irq_o), 64'h1);
        wr(K_CLR, 1, '1);

        // Set and clear in the same cycle (R2)
        evt_i[10] = 1'b1;
        wr(K_CLR, 0, BW'(1) << 10);
        evt_i = '0;
        chk(flags_o[10] == 1'b1, "R2 set wins over clear", 64'(flags_o[10]), 64'h1);
        wr(K_CLR, 0, BW'(1) << 10);
        chk(flags_o[10] == 1'b0, "R2 clear", 64'(flags_o[10]), 64'h0);

        // Software set (R3), then select an already-high event (R10)
        wr(K_SET, 1, BW'(1) << 3);
        chk(flags_o[35] == 1'b1, "R3 software set", 64'(flags_o[35]), 64'h1);
        wr(K_SEL, 1, 32'd35);
        for (int c = 0; c < 3; c++) begin
            chk(irq_o[1] == 1'b0, "R10 no spurious pulse", 64'(irq_o[1]), '0);
            @(negedge clk);
        end
        wr(K_CLR, 1, BW'(1) << 3);
        pulse(35);
        @(negedge clk);
        chk(irq_o == 12'h002, "R7 selector write takes effect", 64'(irq_o), 64'h2);

        // Unused selector value and out-of-range addresses (R11)
        wr(K_SEL, 2, 32'd100);
        pulse(4);
        @(negedge clk);
        chk(irq_o == '0, "R11 unused selector value", 64'(irq_o), '0);
        snap = flags_o;
        wr(K_SET, 3, '1);
        chk(flags_o == snap, "R11 set to absent bank", flags_o, snap);
        wr(K_SEL, 13, 32'd2);
        pulse(13);
        @(negedge clk);
        chk(irq_o == 12'h800, "R11 selector write to absent output", 64'(irq_o), 64'h800);

        // Reserved flags under a full set write (R4)
        wr(K_SET, 0, '1);
        chk(flags_o[BW-1:0] == {{(BW-NB){1'b1}}, {NB{1'b0}}}, "R4 reserved flags stay low",
            64'(flags_o[BW-1:0]), 64'({{(BW-NB){1'b1}}, {NB{1'b0}}}));

        // Reset restores defaults (R7)
        do_reset();
        chk(flags_o == '0, "R1 flags after reset", flags_o, '0);
        pulse(3);
        @(negedge clk);
        chk(irq_o == 12'h002, "R7 selector default after reset", 64'(irq_o), 64'h2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule